// File: doc/BRIEF.md
# Indexed Two-Source Vector Shuffle

This unit rearranges elements of a 256-bit vector built from two 128-bit lanes. Each destination element is picked by an index out of one of two data sources, always from the same lane as the destination element. The element size can be 8, 16, 32 or 64 bits, and the operation can cover one lane (128-bit mode) or both lanes (256-bit mode). A separate cross-lane word mode builds eight 32-bit results, each picked from any word of the whole first source.

An issuing stage presents the operands with a valid strobe. One clock later, the unit presents the complete result with its own valid flag. The whole result is formed from the operands sampled in the strobe cycle, so a caller may pass the old destination value as a source, or as the index vector, and get the old value in every element.

Top module: `vshuf_unit`

## Requirements
- R1: The element size is set by `esize`: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. With m the number of elements per 128-bit lane, each index is the low 8 bits of its index element, reduced modulo 2·m.
- R2: If the reduced index k is below m, the element is element k of the same lane of `src_b`. Otherwise it is element k−m of the same lane of `src_a`.
- R3: In 256-bit mode (`wide`=1), elements of the upper lane read only the upper lanes of the sources. The lane offset is added after the modulo step.
- R4: For 8-bit elements the indices come from `idx_vec`. For 16-, 32- and 64-bit elements they come from `dst_old`, and `idx_vec` has no effect.
- R5: In 128-bit mode (`wide`=0, `xword`=0) the upper 128 bits of the result are zero.
- R6: With `xword`=1 there are eight 32-bit results. Result word w is word (low 8 bits of word w of `src_b`) mod 8 of the full 256-bit `src_a`. In this mode `esize`, `wide`, `idx_vec` and `dst_old` have no effect.
- R7: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. `out_data` holds the result computed from the inputs of that cycle.
- R8: While `in_valid` is low, `out_data` keeps its value.
- R9: A synchronous active-low reset clears `out_valid` and `out_data` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| src_a | input | 256 | First data source |
| src_b | input | 256 | Second data source; also the word indices in cross-lane mode |
| idx_vec | input | 256 | Index vector for 8-bit elements |
| dst_old | input | 256 | Prior destination value; index vector for 16/32/64-bit elements |
| esize | input | 2 | Element size: 0=8, 1=16, 2=32, 3=64 bits |
| wide | input | 1 | 1: 256-bit operation, 0: 128-bit operation |
| xword | input | 1 | Cross-lane word permute mode |
| out_valid | output | 1 | Result valid |
| out_data | output | 256 | Registered result |

## Verification
The bench builds the unit with the default 128-bit lane width and two lanes. This covers every lane element count from sixteen bytes down to two doublewords, so the modulo step runs over widths from five bits down to two. It also covers the lane offset for the upper lane and the eight-word span of the cross-lane mode. Random index bytes fall mostly at or above 2·m, so the wrap path gets steady use. Directed cases add indices exactly at 2·m and at 0xFF, an index vector that changes while `dst_old` is the real index source, and idle cycles with changing inputs.

// File: rtl/vshuf_pkg.sv
// Shared definitions for the vector shuffle unit.
// Assumes the element-size code is two bits wide.
package vshuf_pkg;
    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } esize_e;

    localparam int NUM_SIZES = 4;
    localparam int WORD_W    = 32;
endpackage

// File: rtl/vshuf_lane.sv
// One 128-bit lane of the indexed shuffle. For each element size it builds a
// full lane result: index byte mod 2m picks src_b (k < m) or src_a (k >= m)
// within this lane. Assumes 2m <= 256 so the index fits in the low byte.
module vshuf_lane
    import vshuf_pkg::*;
#(
    parameter int LANE_W = 128
) (
    input  logic [LANE_W-1:0] a_lane,
    input  logic [LANE_W-1:0] b_lane,
    input  logic [LANE_W-1:0] ix_lane,
    input  logic [1:0]        esize,
    output logic [LANE_W-1:0] res
);
    logic [LANE_W-1:0] by_size [NUM_SIZES];
    logic              unused_ix;

    assign unused_ix = ^ix_lane;

    genvar s, e;
    generate
        for (s = 0; s < NUM_SIZES; s++) begin : g_sz
            localparam int EW = 8 << s;
            localparam int M  = LANE_W / EW;
            localparam int KW = $clog2(2 * M);
            logic [EW-1:0]     a_el [M];
            logic [EW-1:0]     b_el [M];
            logic [LANE_W-1:0] r;
            for (e = 0; e < M; e++) begin : g_el
                logic [KW-1:0] k;
                assign a_el[e] = a_lane[e*EW +: EW];
                assign b_el[e] = b_lane[e*EW +: EW];
                // modulo 2m is the low KW bits of the index byte
                assign k = ix_lane[e*EW +: KW];
                assign r[e*EW +: EW] = k[KW-1] ? a_el[k[KW-2:0]] : b_el[k[KW-2:0]];
            end
            assign by_size[s] = r;
        end
    endgenerate

    // Pick the result for the requested element size.
    always_comb begin
        res = by_size[esize];
    end
endmodule

// File: rtl/vshuf_xword.sv
// Cross-lane word permute: every 32-bit result word selects any word of the
// full data vector by the low bits of the matching index word.
// Assumes VEC_W is a power-of-two multiple of 32.
module vshuf_xword
    import vshuf_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic [VEC_W-1:0] data,
    input  logic [VEC_W-1:0] idx,
    output logic [VEC_W-1:0] res
);
    localparam int NW = VEC_W / WORD_W;
    localparam int KW = $clog2(NW);

    logic [WORD_W-1:0] d_w [NW];
    logic              unused_idx;

    assign unused_idx = ^idx;

    genvar w;
    generate
        for (w = 0; w < NW; w++) begin : g_w
            logic [KW-1:0] k;
            assign d_w[w] = data[w*WORD_W +: WORD_W];
            assign k      = idx[w*WORD_W +: KW];
            assign res[w*WORD_W +: WORD_W] = d_w[k];
        end
    endgenerate
endmodule

// File: rtl/vshuf_unit.sv
// Indexed two-source vector shuffle with a one-cycle registered result.
// Picks the index source by element size, runs one lane shuffler per lane,
// zeroes upper lanes in narrow mode, or uses the cross-lane word permute.
// Assumes synchronous active-low reset and that inputs are sampled only
// when in_valid is high.
module vshuf_unit
    import vshuf_pkg::*;
#(
    parameter int LANE_W = 128,
    parameter int NLANES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [LANE_W*NLANES-1:0] src_a,
    input  logic [LANE_W*NLANES-1:0] src_b,
    input  logic [LANE_W*NLANES-1:0] idx_vec,
    input  logic [LANE_W*NLANES-1:0] dst_old,
    input  logic [1:0]               esize,
    input  logic                     wide,
    input  logic                     xword,
    output logic                     out_valid,
    output logic [LANE_W*NLANES-1:0] out_data
);
    localparam int VEC_W = LANE_W * NLANES;

    logic [VEC_W-1:0] ix_sel;
    logic [VEC_W-1:0] lane_res;
    logic [VEC_W-1:0] xw_res;
    logic [VEC_W-1:0] next_data;

    // Byte elements take indices from idx_vec, wider ones from dst_old.
    always_comb begin
        ix_sel = (esize_e'(esize) == SZ_B) ? idx_vec : dst_old;
    end

    genvar l;
    generate
        for (l = 0; l < NLANES; l++) begin : g_lane
            logic [LANE_W-1:0] lane_out;
            vshuf_lane #(.LANE_W(LANE_W)) u_lane (
                .a_lane (src_a[l*LANE_W +: LANE_W]),
                .b_lane (src_b[l*LANE_W +: LANE_W]),
                .ix_lane(ix_sel[l*LANE_W +: LANE_W]),
                .esize  (esize),
                .res    (lane_out)
            );
            if (l == 0) begin : g_base
                assign lane_res[l*LANE_W +: LANE_W] = lane_out;
            end else begin : g_upper
                assign lane_res[l*LANE_W +: LANE_W] = wide ? lane_out : '0;
            end
        end
    endgenerate

    vshuf_xword #(.VEC_W(VEC_W)) u_xword (
        .data(src_a),
        .idx (src_b),
        .res (xw_res)
    );

    // Choose between lane shuffle and cross-lane word permute.
    always_comb begin
        next_data = xword ? xw_res : lane_res;
    end

    // Register the result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= next_data;
            end
        end
    end
endmodule

// File: rtl/vshuf_chk.sv
// Property checker for vshuf_unit, bound to every instance.
// Assumes the lane width is at least 128 bits.
module vshuf_chk #(
    parameter int LANE_W = 128,
    parameter int NLANES = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [LANE_W*NLANES-1:0] src_a,
    input logic [LANE_W*NLANES-1:0] src_b,
    input logic [1:0]               esize,
    input logic                     wide,
    input logic                     xword,
    input logic                     out_valid,
    input logic [LANE_W*NLANES-1:0] out_data
);
    localparam int VEC_W = LANE_W * NLANES;
    localparam int TOP   = (NLANES - 1) * LANE_W;

    p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && rst_n) |=> $stable(out_data));

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide && !xword) |=> (out_data[VEC_W-1:LANE_W] == '0));

    p_lane_local_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !xword && esize == 2'd3) |=>
            (out_data[63:0] == $past(src_a[63:0]) ||
             out_data[63:0] == $past(src_a[127:64]) ||
             out_data[63:0] == $past(src_b[63:0]) ||
             out_data[63:0] == $past(src_b[127:64])));

    p_upper_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && wide && !xword && esize == 2'd3) |=>
            (out_data[TOP+64 +: 64] == $past(src_a[TOP +: 64]) ||
             out_data[TOP+64 +: 64] == $past(src_a[TOP+64 +: 64]) ||
             out_data[TOP+64 +: 64] == $past(src_b[TOP +: 64]) ||
             out_data[TOP+64 +: 64] == $past(src_b[TOP+64 +: 64])));

    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0));
endmodule

bind vshuf_unit vshuf_chk #(.LANE_W(LANE_W), .NLANES(NLANES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .src_a    (src_a),
    .src_b    (src_b),
    .esize    (esize),
    .wide     (wide),
    .xword    (xword),
    .out_valid(out_valid),
    .out_data (out_data)
);

// File: tb/sim_vshuf_unit.sv
module sim_vshuf_unit;
    localparam int LANE_W = 128;
    localparam int NLANES = 2;
    localparam int VEC_W  = LANE_W * NLANES;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [VEC_W-1:0] src_a, src_b, idx_vec, dst_old;
    logic [1:0]       esize;
    logic             wide, xword;
    logic             out_valid;
    logic [VEC_W-1:0] out_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vshuf_unit #(.LANE_W(LANE_W), .NLANES(NLANES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .src_a(src_a), .src_b(src_b), .idx_vec(idx_vec), .dst_old(dst_old),
        .esize(esize), .wide(wide), .xword(xword),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [VEC_W-1:0] rnd_vec();
        logic [VEC_W-1:0] v;
        for (int i = 0; i < VEC_W / 32; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    // Reference result built from the requirement text.
    function automatic logic [VEC_W-1:0] ref_model(
        input logic [VEC_W-1:0] a, b, ix, d,
        input logic [1:0] es, input logic wd, input logic xw);
        logic [VEC_W-1:0] r;
        logic [VEC_W-1:0] isrc;
        r = '0;
        if (xw) begin
            for (int w = 0; w < VEC_W / 32; w++) begin
                int k;
                k = int'(b[w*32 +: 8]) % (VEC_W / 32);
                r[w*32 +: 32] = a[k*32 +: 32];
            end
        end else begin
            int ew, m, nl;
            ew = 8 << es;
            m = LANE_W / ew;
            nl = wd ? NLANES : 1;
            isrc = (es == 2'd0) ? ix : d;
            for (int ln = 0; ln < nl; ln++) begin
                for (int i = 0; i < m; i++) begin
                    int base, k;
                    base = ln * LANE_W;
                    k = int'(isrc[base + i*ew +: 8]) % (2 * m);
                    for (int t = 0; t < ew; t++) begin
                        if (k < m) r[base + i*ew + t] = b[base + k*ew + t];
                        else       r[base + i*ew + t] = a[base + (k-m)*ew + t];
                    end
                end
            end
        end
        return r;
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic check_vec(input string req, input logic [VEC_W-1:0] act,
                             input logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation and check the result one cycle later.
    task automatic run_op(input string req, input logic [VEC_W-1:0] a, b, ix, d,
                          input logic [1:0] es, input logic wd, input logic xw);
        logic [VEC_W-1:0] exp;
        exp = ref_model(a, b, ix, d, es, wd, xw);
        @(negedge clk);
        src_a = a; src_b = b; idx_vec = ix; dst_old = d;
        esize = es; wide = wd; xword = xw; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit({req, " valid"}, out_valid, 1'b1);
        check_vec(req, out_data, exp);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [VEC_W-1:0] a, b, ix, d, held, fill;
        void'($urandom(32'h1234_5678));
        rst_n = 1'b0; in_valid = 1'b0;
        src_a = '0; src_b = '0; idx_vec = '0; dst_old = '0;
        esize = 2'd0; wide = 1'b0; xword = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check_bit("R9 reset valid", out_valid, 1'b0);
        check_vec("R9 reset data", out_data, '0);
        rst_n = 1'b1;

        a = rnd_vec(); b = rnd_vec(); d = rnd_vec();
        // R1/R2: index exactly 2m wraps to 0 -> src_b element 0 (byte size, m=16)
        ix = {32{8'd32}};
        run_op("R1 wrap 2m bytes", a, b, ix, d, 2'd0, 1'b1, 1'b0);
        check_vec("R2 wrap takes b[0]", out_data[7:0], {248'b0, b[7:0]});
        // R1: all-ones index -> k = 2m-1 -> last element of src_a
        ix = {VEC_W{1'b1}};
        run_op("R1 index ff half", a, b, d, ix, 2'd1, 1'b1, 1'b0);
        check_vec("R2 ff takes a last", {240'b0, out_data[15:0]}, {240'b0, a[127:112]});
        // R3: upper lane of doublewords, index 0 -> src_b upper lane element 0
        d = '0;
        run_op("R3 upper lane dword", a, b, rnd_vec(), d, 2'd3, 1'b1, 1'b0);
        check_vec("R3 upper reads upper", {192'b0, out_data[255:192]}, {192'b0, b[191:128]});
        // R4: wider sizes ignore idx_vec; same dst_old, different idx_vec
        d = rnd_vec();
        run_op("R4 word first", a, b, rnd_vec(), d, 2'd2, 1'b1, 1'b0);
        held = out_data;
        run_op("R4 word other idx_vec", a, b, rnd_vec(), d, 2'd2, 1'b1, 1'b0);
        check_vec("R4 idx_vec no effect", out_data, held);
        // R5: narrow mode zeroes the upper half for each size
        for (int s = 0; s < 4; s++)
            run_op("R5 narrow", rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 2'(s), 1'b0, 1'b0);
        // R6: cross-lane word mode, esize and wide ignored
        for (int s = 0; s < 4; s++)
            run_op("R6 cross word", rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), 2'(s), s[0], 1'b1);
        // R8: idle cycles with changing inputs keep out_data; R7 valid low
        held = out_data;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            src_a = rnd_vec(); src_b = rnd_vec(); idx_vec = rnd_vec(); dst_old = rnd_vec();
            in_valid = 1'b0;
            @(negedge clk);
            check_bit("R7 no valid", out_valid, 1'b0);
            check_vec("R8 hold", out_data, held);
        end
        // R7: back-to-back operations
        fill = rnd_vec();
        @(negedge clk);
        src_a = fill; src_b = rnd_vec(); dst_old = rnd_vec(); idx_vec = rnd_vec();
        esize = 2'd1; wide = 1'b1; xword = 1'b0; in_valid = 1'b1;
        a = src_a; b = src_b; d = dst_old; ix = idx_vec;
        @(negedge clk);
        check_vec("R7 back-to-back 1", out_data, ref_model(a, b, ix, d, 2'd1, 1'b1, 1'b0));
        src_b = rnd_vec(); esize = 2'd0;
        b = src_b;
        @(negedge clk);
        in_valid = 1'b0;
        check_bit("R7 back-to-back valid", out_valid, 1'b1);
        check_vec("R7 back-to-back 2", out_data, ref_model(a, b, ix, d, 2'd0, 1'b1, 1'b0));
        // R1 R2 R3 R4 R5 R6: random sweep over sizes, widths and modes
        for (int n = 0; n < 600; n++) begin
            logic [1:0] es;
            logic wd, xw;
            es = 2'($urandom_range(0, 3));
            wd = 1'($urandom_range(0, 1));
            xw = ($urandom_range(0, 7) == 0);
            run_op("R2 random", rnd_vec(), rnd_vec(), rnd_vec(), rnd_vec(), es, wd, xw);
        end
        // R9: reset mid-run clears the output
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_bit("R9 reset valid again", out_valid, 1'b0);
        check_vec("R9 reset data again", out_data, '0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule